// File: doc/BRIEF.md
# Distributed-Arithmetic Second-Order Recursive Filter

This block computes one output sample of a second-order recursive (biquad) filter for each accepted input sample. No multiplier is used: the five words x(n), x(n-1), x(n-2), y(n-1) and y(n-2) are treated as one operand vector. Each cycle, one bit from each word forms a 5-bit address into a 32-entry table. Every entry holds the sum of the coefficients whose address bit is set. The table outputs are added into a shifting accumulator, most significant bit first, so the two's-complement sign weight is handled exactly.

A caller presents a word with `in_valid` while `in_ready` is high. The block then works for 16 cycles, or for 8 cycles when `dual_bit` was high at acceptance. In the faster mode two table reads are made per cycle: one for the current bit plane and one for the next lower plane. At the end it emits a one-cycle `out_valid` pulse with the result, which is saturated to 16 bits. On the same clock edge it shifts the input and output delay lines, and the saturated result becomes the new y(n-1).

Coefficients are 16-bit signed values with 14 fraction bits, held in a parameter. The default example is b0=0.25, b1=0.5, b2=0.25, feedback on y(n-1) of 0.75 and feedback on y(n-2) of -0.25.

Top module: `da_biquad`

## Requirements
- R1: A synchronous reset clears both delay lines and the accumulator. In the cycle after reset, `out_valid` is 0 and `in_ready` is 1. The first output after reset depends only on the input then accepted.
- R2: While a computation runs, `in_ready` is 0. An `in_valid` asserted then is ignored: it does not alter any later output.
- R3: With `dual_bit` = 0 at acceptance, `out_valid` rises on the 16th rising clock edge after the accepting edge.
- R4: With `dual_bit` = 1 at acceptance, `out_valid` rises on the 8th rising clock edge after the accepting edge.
- R5: The output is `sat16(floor((b0*x0 + b1*x1 + b2*x2 + f1*y1 + f2*y2) / 2^14))`. All data words are signed 16-bit integers and all coefficients are signed 16-bit integers with 14 fraction bits. Coefficient order: b0, b1, b2, f1, f2.
- R6: For the same input sequence from reset, the two-bit mode produces outputs identical to those of the one-bit mode.
- R7: On each output, x(n-1) moves to x(n-2), the accepted input becomes x(n-1), y(n-1) moves to y(n-2), and the output becomes y(n-1).
- R8: Results above 32767 give 32767 and results below -32768 give -32768. The saturated value is what is stored into y(n-1).
- R9: `out_valid` is high for exactly one cycle per accepted input.
- R10: The mode is taken from `dual_bit` at the accepting edge. Changing `dual_bit` during a computation has no effect on its latency or result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block idle, an offered word is taken on this edge |
| in_data | input | 16 | Input sample, signed |
| dual_bit | input | 1 | 1 selects two bits per cycle for the accepted sample |
| out_valid | output | 1 | One-cycle pulse, result available |
| out_data | output | 16 | Filter output, signed, saturated |

## Verification
The assertions assume that `dual_bit` and `in_data` matter only at the accepting edge. They also assume that reset is a clean synchronous pulse and that the data width is even, so the two-bit mode divides the word exactly. The stimulus drives inputs only at falling edges. It holds a sample until an edge where `in_ready` was seen high, and it raises reset only once the scoreboard has drained. As a result no computation is cut short. Offers made during busy periods and toggles of `dual_bit` mid-computation are deliberate. They probe the claims that such activity is ignored.

// File: rtl/da_biquad_pkg.sv
package da_biquad_pkg;
  localparam int NTAP = 5;
  localparam int CW   = 16;
  localparam int TW   = CW + 3;
  localparam int NENT = 1 << NTAP;

  typedef logic signed [CW-1:0] coef_t;
  typedef coef_t [NTAP-1:0]     coef_vec_t;
  typedef logic signed [TW-1:0] tsum_t;
  typedef logic [NTAP-1:0]      slice_t;

  // Sum of the coefficients selected by the set bits of one address.
  function automatic tsum_t table_entry(coef_vec_t c, slice_t a);
    tsum_t s;
    s = '0;
    for (int k = 0; k < NTAP; k++) begin
      if (a[k]) s = s + TW'($signed(c[k]));
    end
    return s;
  endfunction
endpackage

// File: rtl/da_coef_table.sv
module da_coef_table
  import da_biquad_pkg::*;
#(
  parameter coef_vec_t COEFS = '0
) (
  input  slice_t addr_hi,
  input  slice_t addr_lo,
  output tsum_t  sum_hi,
  output tsum_t  sum_lo
);
  tsum_t rom [NENT];

  for (genvar i = 0; i < NENT; i++) begin : g_entry
    assign rom[i] = table_entry(COEFS, slice_t'(i));
  end

  assign sum_hi = rom[addr_hi];
  assign sum_lo = rom[addr_lo];
endmodule

// File: rtl/da_state_bank.sv
module da_state_bank
  import da_biquad_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] x_in,
  input  logic          step,
  input  logic          dual,
  input  logic          commit,
  input  logic [DW-1:0] y_new,
  output slice_t        slice_hi,
  output slice_t        slice_lo
);
  logic [DW-1:0] x_cur, x_d1, x_d2, y_d1, y_d2;
  logic [DW-1:0] sh [NTAP];

  always_ff @(posedge clk) begin
    if (rst) begin
      x_cur <= '0;
      x_d1  <= '0;
      x_d2  <= '0;
      y_d1  <= '0;
      y_d2  <= '0;
      for (int k = 0; k < NTAP; k++) sh[k] <= '0;
    end else begin
      if (load) begin
        x_cur <= x_in;
        sh[0] <= x_in;
        sh[1] <= x_d1;
        sh[2] <= x_d2;
        sh[3] <= y_d1;
        sh[4] <= y_d2;
      end else if (step) begin
        for (int k = 0; k < NTAP; k++) sh[k] <= dual ? (sh[k] << 2) : (sh[k] << 1);
      end
      if (commit) begin
        x_d2 <= x_d1;
        x_d1 <= x_cur;
        y_d2 <= y_d1;
        y_d1 <= y_new;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NTAP; k++) begin
      slice_hi[k] = sh[k][DW-1];
      slice_lo[k] = sh[k][DW-2];
    end
  end
endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc
  import da_biquad_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 14,
  parameter int AW   = TW + DW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 step,
  input  logic                 first,
  input  logic                 dual,
  input  tsum_t                t_hi,
  input  tsum_t                t_lo,
  output logic signed [DW-1:0] y_word,
  output logic                 sat_hi,
  output logic                 sat_lo
);
  localparam logic signed [AW-1:0] YMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] YMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [AW-1:0] acc, acc_nx, term, scaled;

  function automatic logic signed [AW-1:0] widen(tsum_t t);
    return AW'(t);
  endfunction

  // Weighted table contribution of the current bit plane(s); the sign
  // plane enters negated.
  function automatic logic signed [AW-1:0] plane_term(tsum_t hi, tsum_t lo,
                                                      logic two, logic sgn);
    logic signed [AW-1:0] v;
    v = two ? (widen(hi) <<< 1) : widen(hi);
    if (sgn) v = -v;
    if (two) v = v + widen(lo);
    return v;
  endfunction

  assign term   = plane_term(t_hi, t_lo, dual, first);
  assign acc_nx = (dual ? (acc <<< 2) : (acc <<< 1)) + term;
  assign scaled = acc_nx >>> FRAC;
  assign sat_hi = scaled > YMAX;
  assign sat_lo = scaled < YMIN;

  always_comb begin
    if (sat_hi)      y_word = YMAX[DW-1:0];
    else if (sat_lo) y_word = YMIN[DW-1:0];
    else             y_word = scaled[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else if (step)    acc <= acc_nx;
  end
endmodule

// File: rtl/da_seq.sv
module da_seq #(
  parameter int DW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic dual_in,
  output logic in_ready,
  output logic accept,
  output logic busy,
  output logic first,
  output logic last,
  output logic dual_q
);
  localparam int CNTW = $clog2(DW);
  localparam logic [CNTW-1:0] END1 = CNTW'(DW - 1);
  localparam logic [CNTW-1:0] END2 = CNTW'(DW / 2 - 1);

  logic [CNTW-1:0] cnt;

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;
  assign first    = busy && (cnt == '0);
  assign last     = busy && (cnt == (dual_q ? END2 : END1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      dual_q <= 1'b0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= '0;
      dual_q <= dual_in;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/da_biquad.sv
module da_biquad
  import da_biquad_pkg::*;
#(
  parameter int        DW        = 16,
  parameter int        COEF_FRAC = 14,
  parameter coef_vec_t COEFS     = {-16'sd4096, 16'sd12288, 16'sd4096, 16'sd8192, 16'sd4096}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          dual_bit,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int AW = TW + DW + 1;

  logic   accept_w, busy_w, first_w, last_w, dual_q;
  logic   sat_hi_w, sat_lo_w;
  slice_t sl_hi, sl_lo;
  tsum_t  t_hi, t_lo;
  logic signed [DW-1:0] y_w;

  da_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dual_in(dual_bit),
    .in_ready(in_ready), .accept(accept_w), .busy(busy_w),
    .first(first_w), .last(last_w), .dual_q(dual_q)
  );

  da_state_bank #(.DW(DW)) u_state (
    .clk(clk), .rst(rst), .load(accept_w), .x_in(in_data),
    .step(busy_w), .dual(dual_q), .commit(last_w), .y_new(y_w),
    .slice_hi(sl_hi), .slice_lo(sl_lo)
  );

  da_coef_table #(.COEFS(COEFS)) u_table (
    .addr_hi(sl_hi), .addr_lo(sl_lo), .sum_hi(t_hi), .sum_lo(t_lo)
  );

  da_shift_acc #(.DW(DW), .FRAC(COEF_FRAC), .AW(AW)) u_acc (
    .clk(clk), .rst(rst), .clear(accept_w), .step(busy_w),
    .first(first_w), .dual(dual_q), .t_hi(t_hi), .t_lo(t_lo),
    .y_word(y_w), .sat_hi(sat_hi_w), .sat_lo(sat_lo_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= last_w;
      if (last_w) out_data <= y_w;
    end
  end
endmodule

// File: rtl/da_biquad_chk.sv
module da_biquad_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          dual_bit,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          accept,
  input logic          last_step,
  input logic          sat_hi,
  input logic          sat_lo
);
  localparam int LW = $clog2(DW) + 2;

  logic [LW-1:0] lat;
  logic          mode_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat    <= '0;
      mode_c <= 1'b0;
    end else if (accept) begin
      lat    <= '0;
      mode_c <= dual_bit;
    end else if (lat != '1) begin
      lat <= lat + 1'b1;
    end
  end

  // R1
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));
  // R2
  a_r2_hold_off: assert property (@(posedge clk) disable iff (rst) accept |=> !in_ready);
  a_r2_busy_until_done: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !last_step) |=> !in_ready);
  // R3, R4, R10
  a_r3_r4_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (lat == LW'(mode_c ? DW / 2 : DW)));
  // R8
  a_r8_sat_high: assert property (@(posedge clk) disable iff (rst)
    (last_step && sat_hi) |=> (out_data == {1'b0, {(DW-1){1'b1}}}));
  a_r8_sat_low: assert property (@(posedge clk) disable iff (rst)
    (last_step && sat_lo) |=> (out_data == {1'b1, {(DW-1){1'b0}}}));
  // R9
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);
endmodule

bind da_biquad da_biquad_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .dual_bit(dual_bit),
  .out_valid(out_valid), .out_data(out_data), .accept(accept_w),
  .last_step(last_w), .sat_hi(sat_hi_w), .sat_lo(sat_lo_w)
);

// File: tb/tb_da_biquad.sv
module tb_da_biquad;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  // Coefficients restated: 0.25, 0.5, 0.25, 0.75, -0.25 with 14 fraction bits.
  localparam longint CB0 = 4096, CB1 = 8192, CB2 = 4096, CF1 = 12288, CF2 = -4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        dual_bit = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;

  da_biquad dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .dual_bit(dual_bit), .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    longint y;
    int     acc_cyc;
    bit     mode;
    string  tag;
  } item_t;

  item_t       sb [$];
  logic [15:0] cap [$];
  bit          cap_en = 1'b0;
  int          cyc = 0;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  bit          prev_ov = 1'b0;
  longint      mx1 = 0, mx2 = 0, my1 = 0, my2 = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(input longint x);
    longint s, y;
    s = CB0 * x + CB1 * mx1 + CB2 * mx2 + CF1 * my1 + CF2 * my2;
    y = s >>> 14;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    mx2 = mx1; mx1 = x; my2 = my1; my1 = y;
    return y;
  endfunction

  // Monitor: pops expected items and compares as results appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        check(!prev_ov, "R9", 1, 0);
        if (sb.size() == 0) begin
          check(1'b0, "R5 unexpected output", $signed(out_data), 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check($signed(out_data) == it.y, it.tag, $signed(out_data), it.y);
          check((cyc - it.acc_cyc) == (it.mode ? 8 : 16), it.mode ? "R4" : "R3",
                cyc - it.acc_cyc, it.mode ? 8 : 16);
          if (cap_en) cap.push_back(out_data);
        end
      end
      prev_ov = out_valid;
    end else begin
      prev_ov = 1'b0;
    end
  end

  task automatic send(input logic [15:0] x, input bit m, input bit junk, input bit flip,
                      input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    dual_bit = m;
    while (!in_ready) @(negedge clk);
    it.y       = model(longint'($signed(x)));
    it.acc_cyc = cyc + 1;
    it.mode    = m;
    it.tag     = tag;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
    if (flip) dual_bit = !m;
    if (junk) begin
      for (int i = 0; i < 3; i++) begin
        in_valid = 1'b1;
        in_data  = 16'h5a5a;
        check(!in_ready, "R2 ready while busy", in_ready, 0);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    wait (sb.size() == 0);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    check(!out_valid && in_ready, "R1 idle after reset", {out_valid, in_ready}, 1);
  endtask

  initial begin
    logic [15:0] lfsr;
    logic [15:0] saved [$];
    lfsr = 16'hace1;
    do_reset();

    // R1/R5: impulse from cleared state, then R7 delay-line progression.
    send(16'd16384, 1'b0, 1'b0, 1'b0, "R1 first output");
    for (int i = 0; i < 4; i++) send(16'd0, 1'b0, 1'b0, 1'b0, "R7 delay line");

    // R5 varied words in both modes.
    for (int i = 0; i < 12; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr, i[0], 1'b0, 1'b0, i[0] ? "R6 value" : "R5 value");
    end

    // R2 offers during busy periods; R10 mode toggled mid-run.
    send(16'h1234, 1'b0, 1'b1, 1'b0, "R2 junk ignored");
    send(16'hf000, 1'b1, 1'b1, 1'b0, "R2 junk ignored");
    send(16'h0800, 1'b0, 1'b0, 1'b1, "R10 mode held");
    send(16'h9abc, 1'b1, 1'b0, 1'b1, "R10 mode held");
    send(16'd0,    1'b0, 1'b0, 1'b0, "R2 state clean");

    // R8 saturation both ways, with saturated feedback.
    for (int i = 0; i < 6; i++) send(16'h7fff, i[0], 1'b0, 1'b0, "R8 positive clip");
    for (int i = 0; i < 6; i++) send(16'h8000, i[0], 1'b0, 1'b0, "R8 negative clip");

    // R6: same sequence in each mode from reset.
    do_reset();
    cap_en = 1'b1;
    lfsr = 16'h1357;
    for (int i = 0; i < 10; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr, 1'b0, 1'b0, 1'b0, "R5 one-bit run");
    end
    wait (sb.size() == 0);
    saved = cap;
    cap.delete();
    do_reset();
    lfsr = 16'h1357;
    for (int i = 0; i < 10; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr, 1'b1, 1'b0, 1'b0, "R6 two-bit run");
    end
    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
    check(cap.size() == saved.size(), "R6 count", cap.size(), saved.size());
    for (int i = 0; i < saved.size() && i < cap.size(); i++)
      check(cap[i] == saved[i], "R6 mode match", $signed(cap[i]), $signed(saved[i]));

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule